// File: doc/BRIEF.md
# Three-Wire Configuration Register Loader

This block is the slave end of a three-wire serial bus (bus clock, bus data and an active-low enable) that an external controller uses to program the settings of a radio transceiver. While enable is held low, each rising edge of the bus clock shifts one data bit into a 24-bit shift register, most significant bit first. When enable returns high, the word is copied into one of two configuration registers. The bit shifted last is the address and selects the register.

Register one holds the channel-related settings: reference divider choice, swallow count, main count, oscillator select, filter and compensation enables, deviation and pretune trims, and pump current. Register two holds the production trims: demodulator trim, compensation scaling and test-mode selection. Every field drives its own output port.

The bus pins are brought into the system clock domain through a synchroniser, and their edges are detected there. The system clock must therefore run well above 8 MHz. A transfer sends no length, so leading bits beyond the word length fall out of the top of the shift register and are lost.

Top module: `tw_cfg_loader`

## Requirements
- R1: After reset, every field output is zero.
- R2: Bus clock edges that occur while enable is high do not change the shift register. A later transfer therefore loads exactly what the last enabled transfer shifted in.
- R3: Data is sampled on rising edges of the bus clock and enters MSB first, so the first bit sent ends up highest.
- R4: On the rising edge of enable, the final bit shifted chooses the target. A 1 loads register one from shift bits 23..1, and a 0 loads register two from shift bits 11..1. The other register keeps its value.
- R5: Register one is decoded by data-bit position (the address bit excluded) as follows: refDiv = D22..D21, swallowCnt = D20..D16, mainSel = D15..D14, vcoSel = D13, testExt = D11, gfEn = D10, mccEn = D9, gfDev = D8..D6, vcoTrim = D5..D3, cpCur = D2..D0. D12 drives nothing.
- R6: Register two is decoded as demodTrim = E10..E6, mccScale = E5..E3, testMode = E2..E0.
- R7: Leading bits beyond 24 in one transfer are dropped silently, and no bit count is checked. A register-two transfer uses only the final 12 bits shifted.
- R8: A transfer shorter than the word length, or an enable pulse with no clock edges, loads whatever the shift register then holds. This includes bits left over from earlier transfers.
- R9: Field outputs change only on a load. While a transfer is shifting, they keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busClk | input | 1 | Serial bus clock |
| busData | input | 1 | Serial bus data |
| busEnN | input | 1 | Serial bus enable, active low |
| refDiv | output | 2 | Reference divider select |
| swallowCnt | output | 5 | Swallow counter setting |
| mainSel | output | 2 | Main counter select |
| vcoSel | output | 1 | Oscillator select (0 receive, 1 transmit) |
| testExt | output | 1 | Test selection extension bit |
| gfEn | output | 1 | Transmit data filter enable |
| mccEn | output | 1 | Modulation compensation enable |
| gfDev | output | 3 | Filter deviation setting |
| vcoTrim | output | 3 | Oscillator pretune trim |
| cpCur | output | 3 | Charge-pump current setting |
| demodTrim | output | 5 | Demodulator centre trim |
| mccScale | output | 3 | Compensation scaling setting |
| testMode | output | 3 | Test mode select |

## Verification
The assertions check the following on every cycle:
- a shift strobe moves the register up by one and inserts the sampled bit;
- without a strobe, the shift register holds;
- a load copies the correct slice into the addressed register;
- a register that is not addressed holds.

Only the bench scenarios can show the end-to-end behaviour at the pins:
- bit order;
- the decode of each field;
- the loss of excess leading bits;
- the reuse of stale bits by short transfers and empty enable pulses;
- the fact that clock pulses outside enable are ignored.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef struct packed {
    logic shift;
    logic load;
    logic dataBit;
  } twStrobe_t;
endpackage

// File: rtl/tw_bus_ctrl.sv
module tw_bus_ctrl
  import tw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      busClk,
  input  logic      busData,
  input  logic      busEnN,
  output twStrobe_t strb
);
  localparam int LAST = SYNC_STAGES - 1;
  // bit 2 enable, bit 1 data, bit 0 clock
  localparam logic [2:0] IDLE = 3'b100;

  logic [2:0] syncQ [SYNC_STAGES];
  logic       clkPrev, enPrev;
  logic [2:0] syncOut;

  assign syncOut = syncQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= IDLE;
      clkPrev <= 1'b0;
      enPrev  <= 1'b1;
    end else begin
      syncQ[0] <= {busEnN, busData, busClk};
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      clkPrev <= syncOut[0];
      enPrev  <= syncOut[2];
    end
  end

  always_comb begin
    strb.shift   = syncOut[0] & ~clkPrev & ~syncOut[2];
    strb.load    = syncOut[2] & ~enPrev;
    strb.dataBit = syncOut[1];
  end
endmodule

// File: rtl/tw_cfg_datapath.sv
module tw_cfg_datapath
  import tw_pkg::*;
#(
  parameter int W1_W  = 23,
  parameter int W2_W  = 11,
  parameter int SPARE = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  twStrobe_t          strb,
  output logic [W1_W-2:0]    word1,
  output logic [W2_W-1:0]    word2
);
  localparam int SHIFT_W = W1_W + 1;

  logic [SHIFT_W-1:0] shiftReg;
  logic [W1_W-2:0]    w1Q;
  logic [W2_W-1:0]    w2Q;
  logic               addrBit;

  assign addrBit = shiftReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      w1Q      <= '0;
      w2Q      <= '0;
    end else begin
      if (strb.shift) shiftReg <= {shiftReg[SHIFT_W-2:0], strb.dataBit};
      if (strb.load && addrBit)
        w1Q <= {shiftReg[SHIFT_W-1:SPARE+2], shiftReg[SPARE:1]};
      if (strb.load && !addrBit)
        w2Q <= shiftReg[W2_W:1];
    end
  end

  assign word1 = w1Q;
  assign word2 = w2Q;

  // R3
  shift_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> shiftReg == {$past(shiftReg[SHIFT_W-2:0]), $past(strb.dataBit)});
  // R2
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> $stable(shiftReg));
  // R4
  w1_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && addrBit) |=> w1Q == {$past(shiftReg[SHIFT_W-1:SPARE+2]), $past(shiftReg[SPARE:1])});
  // R4
  w2_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !addrBit) |=> w2Q == $past(shiftReg[W2_W:1]));
  // R9
  w1_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load && addrBit) |=> $stable(w1Q));
  // R9
  w2_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load && !addrBit) |=> $stable(w2Q));
endmodule

// File: rtl/tw_cfg_loader.sv
module tw_cfg_loader
  import tw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busClk,
  input  logic       busData,
  input  logic       busEnN,
  output logic [1:0] refDiv,
  output logic [4:0] swallowCnt,
  output logic [1:0] mainSel,
  output logic       vcoSel,
  output logic       testExt,
  output logic       gfEn,
  output logic       mccEn,
  output logic [2:0] gfDev,
  output logic [2:0] vcoTrim,
  output logic [2:0] cpCur,
  output logic [4:0] demodTrim,
  output logic [2:0] mccScale,
  output logic [2:0] testMode
);
  localparam int W1_W = 23;
  localparam int W2_W = 11;

  twStrobe_t       strb;
  logic [W1_W-2:0] word1;
  logic [W2_W-1:0] word2;

  tw_bus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busClk(busClk), .busData(busData),
    .busEnN(busEnN), .strb(strb)
  );

  tw_cfg_datapath #(.W1_W(W1_W), .W2_W(W2_W), .SPARE(12)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .word1(word1), .word2(word2)
  );

  // word1 packs D22..D13 above D11..D0
  assign {refDiv, swallowCnt, mainSel, vcoSel} = word1[21:12];
  assign {testExt, gfEn, mccEn, gfDev, vcoTrim, cpCur} = word1[11:0];
  assign {demodTrim, mccScale, testMode} = word2;
endmodule

// File: tb/tb_tw_cfg_loader.sv
module tb_tw_cfg_loader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busClk = 1'b0, busData = 1'b0, busEnN = 1'b1;
  logic [1:0] refDiv, mainSel;
  logic [4:0] swallowCnt, demodTrim;
  logic vcoSel, testExt, gfEn, mccEn;
  logic [2:0] gfDev, vcoTrim, cpCur, mccScale, testMode;

  int checks = 0;
  int fails = 0;
  logic [23:0] hist = '0;
  logic [21:0] expW1 = '0;
  logic [10:0] expW2 = '0;

  localparam int NVEC = 6;
  localparam logic [29:0] VEC_BITS [NVEC] = '{
    30'h00B3C5A7, 30'h00000A56, 30'h004F0E33,
    30'h3FC12345, 30'h000F5ACE, 30'h000003F0};
  localparam int VEC_LEN [NVEC] = '{24, 12, 24, 30, 20, 12};

  always #4 clk = ~clk;

  tw_cfg_loader dut (
    .clk(clk), .rstN(rstN), .busClk(busClk), .busData(busData), .busEnN(busEnN),
    .refDiv(refDiv), .swallowCnt(swallowCnt), .mainSel(mainSel), .vcoSel(vcoSel),
    .testExt(testExt), .gfEn(gfEn), .mccEn(mccEn), .gfDev(gfDev), .vcoTrim(vcoTrim),
    .cpCur(cpCur), .demodTrim(demodTrim), .mccScale(mccScale), .testMode(testMode));

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftBits(input logic [29:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      busData = v[i];
      waitCyc(10);
      busClk = 1'b1;
      waitCyc(10);
      busClk = 1'b0;
      hist = {hist[22:0], v[i]};
    end
  endtask

  // expected load from requirements R4/R5/R6
  task automatic endXfer();
    waitCyc(10);
    busEnN = 1'b1;
    if (hist[0]) expW1 = {hist[23:14], hist[12:1]};
    else expW2 = hist[11:1];
    waitCyc(40);
  endtask

  task automatic sendWord(input logic [29:0] v, input int n);
    busEnN = 1'b0;
    waitCyc(30);
    shiftBits(v, n);
    endXfer();
  endtask

  task automatic checkOuts(input string req);
    logic [21:0] obs1;
    logic [10:0] obs2;
    obs1 = {refDiv, swallowCnt, mainSel, vcoSel, testExt, gfEn, mccEn, gfDev, vcoTrim, cpCur};
    obs2 = {demodTrim, mccScale, testMode};
    checks++;
    if (obs1 !== expW1) begin
      fails++;
      $display("FAIL %s word1 fields: actual %h expected %h", req, obs1, expW1);
    end
    checks++;
    if (obs2 !== expW2) begin
      fails++;
      $display("FAIL %s word2 fields: actual %h expected %h", req, obs2, expW2);
    end
  endtask

  function automatic string vecReq(input int i);
    case (i)
      0, 2: return "R5 R3 R4";
      1, 5: return "R6 R4";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    waitCyc(5);
    // R1 reset state
    checkOuts("R1");
    rstN = 1'b1;
    waitCyc(5);
    checkOuts("R1");

    for (int i = 0; i < NVEC; i++) begin
      sendWord(VEC_BITS[i], VEC_LEN[i]);
      checkOuts(vecReq(i));
    end

    // R5 single field: only gfEn (D10) set, address 1
    sendWord(30'h00000801, 24);
    checks++;
    if (gfEn !== 1'b1 || cpCur !== 3'd0 || swallowCnt !== 5'd0) begin
      fails++;
      $display("FAIL R5 gfEn: actual %b expected 1", gfEn);
    end

    // R9 outputs stable mid-transfer
    busEnN = 1'b0;
    waitCyc(30);
    shiftBits(30'h00000ABC, 12);
    waitCyc(20);
    checkOuts("R9");
    shiftBits(30'h00000F35, 12);
    endXfer();
    checkOuts("R9 R3");

    // R2 clocks with enable high ignored, then empty enable pulse reloads
    shiftBits(30'h00000FFE, 0);
    for (int k = 0; k < 6; k++) begin
      busData = k[0];
      waitCyc(10);
      busClk = 1'b1;
      waitCyc(10);
      busClk = 1'b0;
    end
    waitCyc(20);
    busEnN = 1'b0;
    waitCyc(30);
    endXfer();
    checkOuts("R2 R8");

    // R8 short one-bit transfer reuses stale bits
    sendWord(30'h0, 1);
    checkOuts("R8");
    sendWord(30'h1, 1);
    checkOuts("R8");

    // R1 reset mid-operation
    rstN = 1'b0;
    hist = '0;
    expW1 = '0;
    expW2 = '0;
    waitCyc(3);
    checkOuts("R1");
    rstN = 1'b1;
    waitCyc(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule